// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit

This block is the arithmetic core of a fixed-point signal-processing datapath. It multiplies two 16-bit operands and combines the product with a 40-bit accumulator value in one clock. Each operand has its own signed/unsigned control, and that control decides how the operand is widened to 17 bits. The multiplier is therefore a 17 x 17 two's-complement array that handles every mix of signed and unsigned inputs.

A fractional mode doubles the product before it is combined. An operation code selects one of three results: the product alone, the accumulator plus the product, or the accumulator minus the product. After the 40-bit sum the block can round to the upper word. It then checks the value against the signed 32-bit range and, when asked, clamps it to that range. Result, overflow and zero flags are registered together.

A 16-bit holding register can stand in for the second multiplier operand, which suits loops that reuse one coefficient or sample. Fetching operands, storing the accumulator and sequencing instructions are left to the surrounding datapath.

Top module: `mac17_unit`

## Requirements
- R1: While reset is low, and after it is released, the result is 0, the overflow flag is 0, the zero flag is 1 and the holding register is 0.
- R2: Each operand is widened to 17 bits. It is sign-extended from bit 15 when its signed control is 1 and zero-extended when it is 0. With op code 2'b00 the result is the full 17 x 17 product, sign-extended to 40 bits. The result appears after the clock edge at which `issue` is high.
- R3: Op code 2'b01 gives `acc_in` + product, op code 2'b10 gives `acc_in` - product, and op code 2'b11 behaves like 2'b00. All sums wrap modulo 2^40.
- R4: When `frac_mode` is 1, the product is doubled (shifted left by one bit) before it is combined with the accumulator.
- R5: When `round_en` is 1, 0x8000 is added to the 40-bit sum and bits 15:0 are then cleared, modulo 2^40.
- R6: `ovf` is 1 exactly when the rounded value lies outside the signed 32-bit range, i.e. when bits 39:31 are not all equal. This holds whether or not saturation is enabled.
- R7: When `sat_en` is 1 and the value overflows, the result becomes 0x007FFFFFFF if bit 39 of the rounded value is 0, and 0xFF80000000 if it is 1.
- R8: `zero` is 1 exactly when all 40 bits of the final result (after rounding and saturation) are zero.
- R9: `t_load` writes `t_data` into the holding register at the clock edge. When `use_t` is 1, the holding register replaces `b_data` as the second operand. An issue in the same cycle as a load uses the value held before that edge.
- R10: While `issue` is 0, the result and both flags hold their values, whatever the other inputs do, including a holding-register load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| t_load | input | 1 | Write `t_data` into the holding register |
| t_data | input | 16 | Value for the holding register |
| issue | input | 1 | Perform an operation this cycle |
| op_sel | input | 2 | 00 multiply, 01 multiply-add, 10 multiply-subtract, 11 multiply |
| a_data | input | 16 | First multiplier operand |
| b_data | input | 16 | Second multiplier operand |
| use_t | input | 1 | Take the second operand from the holding register |
| a_signed | input | 1 | First operand is signed |
| b_signed | input | 1 | Second operand is signed |
| frac_mode | input | 1 | Double the product |
| round_en | input | 1 | Round to bit 16 |
| sat_en | input | 1 | Clamp to the signed 32-bit range |
| acc_in | input | 40 | Accumulator value |
| result | output | 40 | Registered result |
| ovf | output | 1 | Result exceeded the signed 32-bit range |
| zero | output | 1 | Result is all zero |

## Verification
The only state is the holding register and the registered result and flags. A wrong internal value therefore reaches the ports at the first edge where it is used. A bad operand extension, scaling or rounding step changes `result` one cycle after the issue that exercises it. A stale or wrongly loaded holding register shows up one cycle after the next issue with `use_t` set. The sweep pairs boundary operands (0, ±1, the extreme positives and negatives) with accumulators near the 40-bit limits and the 32-bit saturation edges. This places every sign, carry and clamp decision where a single-bit error changes the observed word or flag.

// File: rtl/mac17_pkg.sv
package mac17_pkg;

    typedef enum logic [1:0] {
        OP_MUL  = 2'b00,
        OP_ADD  = 2'b01,
        OP_SUB  = 2'b10,
        OP_MULX = 2'b11
    } mac_op_e;

endpackage

// File: rtl/mac17_mul.sv
module mac17_mul #(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input  logic [DW-1:0] a_op,
    input  logic [DW-1:0] b_op,
    input  logic          a_sgn,
    input  logic          b_sgn,
    input  logic          frac,
    output logic [AW-1:0] prod_ext
);
    localparam int XW = DW + 1;
    localparam int PW = 2 * XW;

    logic [DW-1:0]        op_in [2];
    logic                 op_sg [2];
    logic signed [XW-1:0] op_x  [2];
    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] prod_w;

    assign op_in[0] = a_op;
    assign op_in[1] = b_op;
    assign op_sg[0] = a_sgn;
    assign op_sg[1] = b_sgn;

    for (genvar i = 0; i < 2; i++) begin : g_ext
        // widen each operand by one bit; the extra bit follows the sign control
        assign op_x[i] = {op_sg[i] & op_in[i][DW-1], op_in[i]};
    end

    assign prod   = op_x[0] * op_x[1];
    assign prod_w = AW'(prod);

    always_comb begin
        prod_ext = frac ? (prod_w <<< 1) : prod_w;
    end

endmodule

// File: rtl/mac17_post.sv
module mac17_post
    import mac17_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 40,
    parameter int SW = 32
) (
    input  logic [AW-1:0] acc,
    input  logic [AW-1:0] prod,
    input  mac_op_e       op,
    input  logic          rnd_en,
    input  logic          sat_on,
    output logic [AW-1:0] res,
    output logic          ovf_o,
    output logic          zero_o
);
    localparam int            HW       = AW - SW + 1;
    localparam logic [AW-1:0] RND_ONE  = AW'(1) << (DW - 1);
    localparam logic [AW-1:0] RND_MASK = ~((AW'(1) << DW) - AW'(1));
    localparam logic [AW-1:0] SAT_POS  = {{HW{1'b0}}, {(SW-1){1'b1}}};
    localparam logic [AW-1:0] SAT_NEG  = ~SAT_POS;

    logic [AW-1:0] sum;
    logic [AW-1:0] rnd;
    logic [HW-1:0] hi;

    always_comb begin
        case (op)
            OP_ADD:  sum = acc + prod;
            OP_SUB:  sum = acc - prod;
            default: sum = prod;
        endcase

        rnd = rnd_en ? ((sum + RND_ONE) & RND_MASK) : sum;

        hi    = rnd[AW-1:SW-1];
        ovf_o = !((&hi) || !(|hi));

        if (sat_on && ovf_o) begin
            res = rnd[AW-1] ? SAT_NEG : SAT_POS;
        end else begin
            res = rnd;
        end

        zero_o = !(|res);
    end

endmodule

// File: rtl/mac17_unit.sv
module mac17_unit
    import mac17_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 40,
    parameter int SW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          t_load,
    input  logic [DW-1:0] t_data,
    input  logic          issue,
    input  logic [1:0]    op_sel,
    input  logic [DW-1:0] a_data,
    input  logic [DW-1:0] b_data,
    input  logic          use_t,
    input  logic          a_signed,
    input  logic          b_signed,
    input  logic          frac_mode,
    input  logic          round_en,
    input  logic          sat_en,
    input  logic [AW-1:0] acc_in,
    output logic [AW-1:0] result,
    output logic          ovf,
    output logic          zero
);
    typedef struct packed {
        logic [DW-1:0] t;
        logic [AW-1:0] res;
        logic          ovf;
        logic          zero;
    } state_t;

    state_t state_d, state_q;

    logic [DW-1:0] b_sel;
    logic [AW-1:0] prod_ext;
    logic [AW-1:0] post_res;
    logic          post_ovf;
    logic          post_zero;

    assign b_sel = use_t ? state_q.t : b_data;

    mac17_mul #(.DW(DW), .AW(AW)) u_mul (
        .a_op     (a_data),
        .b_op     (b_sel),
        .a_sgn    (a_signed),
        .b_sgn    (b_signed),
        .frac     (frac_mode),
        .prod_ext (prod_ext)
    );

    mac17_post #(.DW(DW), .AW(AW), .SW(SW)) u_post (
        .acc    (acc_in),
        .prod   (prod_ext),
        .op     (mac_op_e'(op_sel)),
        .rnd_en (round_en),
        .sat_on (sat_en),
        .res    (post_res),
        .ovf_o  (post_ovf),
        .zero_o (post_zero)
    );

    always_comb begin
        state_d = state_q;
        if (t_load) begin
            state_d.t = t_data;
        end
        if (issue) begin
            state_d.res  = post_res;
            state_d.ovf  = post_ovf;
            state_d.zero = post_zero;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.t    <= '0;
            state_q.res  <= '0;
            state_q.ovf  <= 1'b0;
            state_q.zero <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign result = state_q.res;
    assign ovf    = state_q.ovf;
    assign zero   = state_q.zero;

endmodule

// File: rtl/mac17_unit_chk.sv
module mac17_unit_chk #(
    parameter int DW = 16,
    parameter int AW = 40,
    parameter int SW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          issue,
    input logic          round_en,
    input logic          sat_en,
    input logic          t_load,
    input logic [DW-1:0] t_data,
    input logic [DW-1:0] t_val,
    input logic [AW-1:0] result,
    input logic          ovf,
    input logic          zero
);
    localparam int HW = AW - SW + 1;

    logic in_range;
    assign in_range = (result[AW-1:SW-1] == {HW{1'b0}}) || (result[AW-1:SW-1] == {HW{1'b1}});

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (result == '0 && !ovf && zero && t_val == '0));

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> ($stable(result) && $stable(ovf) && $stable(zero)));

    // R8
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero == (result == '0));

    // R7
    sat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && sat_en) |=> in_range);

    // R6
    ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !sat_en) |=> (ovf == !in_range));

    // R5
    round_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && round_en && !sat_en) |=> (result[DW-1:0] == '0));

    // R9
    t_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_load |=> (t_val == $past(t_data)));

endmodule

bind mac17_unit mac17_unit_chk #(.DW(DW), .AW(AW), .SW(SW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue    (issue),
    .round_en (round_en),
    .sat_en   (sat_en),
    .t_load   (t_load),
    .t_data   (t_data),
    .t_val    (state_q.t),
    .result   (result),
    .ovf      (ovf),
    .zero     (zero)
);

// File: tb/mac17_unit_tb.sv
`timescale 1ns/1ps
module mac17_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        t_load = 1'b0;
    logic [15:0] t_data = '0;
    logic        issue = 1'b0;
    logic [1:0]  op_sel = '0;
    logic [15:0] a_data = '0;
    logic [15:0] b_data = '0;
    logic        use_t = 1'b0;
    logic        a_signed = 1'b0;
    logic        b_signed = 1'b0;
    logic        frac_mode = 1'b0;
    logic        round_en = 1'b0;
    logic        sat_en = 1'b0;
    logic [39:0] acc_in = '0;
    logic [39:0] result;
    logic        ovf;
    logic        zero;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mac17_unit u_dut (
        .clk(clk), .rst_n(rst_n), .t_load(t_load), .t_data(t_data),
        .issue(issue), .op_sel(op_sel), .a_data(a_data), .b_data(b_data),
        .use_t(use_t), .a_signed(a_signed), .b_signed(b_signed),
        .frac_mode(frac_mode), .round_en(round_en), .sat_en(sat_en),
        .acc_in(acc_in), .result(result), .ovf(ovf), .zero(zero)
    );

    localparam longint M40 = 64'h00FF_FFFF_FFFF;

    logic [15:0] vals [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                              16'hFFFF, 16'h1234, 16'hC000, 16'h0100};
    logic [39:0] accs [6] = '{40'h00_0000_0000, 40'h00_0000_0001, 40'h7F_FFFF_FFFF,
                              40'h80_0000_0000, 40'hFF_FFFF_8000, 40'h00_4000_0000};

    task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // arithmetic reference taken from the requirements
    task automatic model(input logic [15:0] a, input logic [15:0] b, input bit sa, input bit sb,
                         input bit fr, input logic [1:0] op, input bit rd, input bit st,
                         input logic [39:0] acc,
                         output logic [39:0] e_res, output logic e_ovf, output logic e_zero);
        longint pa, pb, pr, av, s, sv;
        pa = sa ? longint'({{48{a[15]}}, a}) : longint'({48'b0, a});
        pb = sb ? longint'({{48{b[15]}}, b}) : longint'({48'b0, b});
        pr = pa * pb;
        if (fr) pr = pr * 2;
        av = longint'({{24{acc[39]}}, acc});
        case (op)
            2'b01:   s = av + pr;
            2'b10:   s = av - pr;
            default: s = pr;
        endcase
        s = s & M40;
        if (rd) s = (s + 64'h8000) & 64'h00FF_FFFF_0000;
        sv = s[39] ? (s | ~M40) : s;
        e_ovf = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
        if (st && e_ovf) s = sv < 0 ? 64'h00FF_8000_0000 : 64'h0000_7FFF_FFFF;
        e_res = s[39:0];
        e_zero = (e_res == '0);
    endtask

    task automatic run_op(input string tag, input logic [15:0] a, input logic [15:0] b,
                          input bit sa, input bit sb, input bit fr, input logic [1:0] op,
                          input bit rd, input bit st, input logic [39:0] acc);
        logic [39:0] er;
        logic eo, ez;
        @(negedge clk);
        issue = 1; use_t = 0; a_data = a; b_data = b; a_signed = sa; b_signed = sb;
        frac_mode = fr; op_sel = op; round_en = rd; sat_en = st; acc_in = acc;
        model(a, b, sa, sb, fr, op, rd, st, acc, er, eo, ez);
        @(negedge clk);
        issue = 0;
        chk(tag, result, er);
        chk("R6 ovf", {39'b0, ovf}, {39'b0, eo});
        chk("R8 zero", {39'b0, zero}, {39'b0, ez});
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 result", result, '0);
        chk("R1 ovf", {39'b0, ovf}, '0);
        chk("R1 zero", {39'b0, zero}, 40'd1);
        rst_n = 1;
        @(negedge clk);
        chk("R1 after release", result, '0);

        // R9: load T and issue together -> old T (0) is used
        t_load = 1; t_data = 16'd5; issue = 1; use_t = 1; a_data = 16'd2;
        a_signed = 1; b_signed = 1; op_sel = 2'b00; frac_mode = 0; round_en = 0; sat_en = 0;
        b_data = 16'd9;
        @(negedge clk);
        t_load = 0;
        chk("R9 old T used", result, '0);
        @(negedge clk);
        chk("R9 new T used", result, 40'd10);
        // R10: load without issue leaves result alone
        issue = 0; t_load = 1; t_data = 16'hFFFF; a_data = 16'h7FFF; acc_in = 40'h123;
        @(negedge clk);
        t_load = 0;
        chk("R10 hold on load", result, 40'd10);
        op_sel = 2'b01; round_en = 1;
        @(negedge clk);
        chk("R10 hold idle", result, 40'd10);
        chk("R10 zero hold", {39'b0, zero}, '0);
        round_en = 0; op_sel = 2'b00;
        issue = 1; a_data = 16'd3; use_t = 1;
        @(negedge clk);
        issue = 0;
        chk("R9 signed T -1", result, 40'hFF_FFFF_FFFD);

        // R3: op code 11 acts as multiply only
        run_op("R3 op11", 16'd3, 16'd4, 0, 0, 0, 2'b11, 0, 0, 40'd100);
        run_op("R3 op11 frac", 16'h8000, 16'h8000, 1, 1, 1, 2'b11, 0, 0, 40'd7);
        // R8: exact cancellation
        run_op("R8 cancel", 16'd1, 16'd1, 0, 0, 0, 2'b10, 0, 0, 40'd1);

        // near-exhaustive sweep
        for (int ia = 0; ia < 8; ia++)
            for (int ib = 0; ib < 8; ib++)
                for (int sg = 0; sg < 4; sg++)
                    for (int fr = 0; fr < 2; fr++)
                        for (int op = 0; op < 3; op++)
                            for (int rs = 0; rs < 4; rs++)
                                for (int ic = 0; ic < 6; ic++) begin
                                    string tg;
                                    if (rs[1])      tg = "R7 sat";
                                    else if (rs[0]) tg = "R5 round";
                                    else if (fr[0]) tg = "R4 frac";
                                    else if (op != 0) tg = "R3 acc";
                                    else            tg = "R2 product";
                                    run_op(tg, vals[ia], vals[ib], sg[1], sg[0], fr[0],
                                           op[1:0], rs[0], rs[1], accs[ic]);
                                end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule